// File: doc/BRIEF.md
# Conditional Instruction Dispatch Unit

This block sits between the instruction fetch path of a convolution accelerator and its six operation engines. Instruction words arrive one per cycle over a valid/ready handshake. They form units. Each unit is one command word followed by one or more parameter words. The command word names the target engine and a trigger mask. The parameter words only carry settings for that command and never start anything by themselves.

Once all the parameter words of a unit are collected, the block holds the unit and stops taking input. It waits until every engine named in the trigger mask has reported done since the last issue to the same target engine. It then raises a one-cycle start on that engine's issue port and presents the collected parameters on that port's flat parameter bus. Malformed words are dropped and set a sticky error flag. A whole block of many units is streamed into one dispatcher, which serves one processing-element group.

Top module: `cond_issue_dispatch`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), in_ready is 1, err_o is 0, start_o is all zero and param_o is all zero.
- R2: The word format is as follows. Bit 31 set marks a command word and bit 31 clear marks a parameter word. In a command word, bits 30:28 are the opcode, bits 27:22 are the trigger mask, and bits 21:18 are the parameter count, legal from 1 to 8. Trigger mask bit j refers to done_i[j]. The opcodes are: 0 memory read, 1 memory write, 2 data fetch, 3 compute, 4 post-process, 5 instruction read. Opcode k drives start_o[k].
- R3: A legal unit issues exactly once. start_o[opcode] is high for a single cycle and every other start_o bit stays low.
- R4: In the start cycle, the slice of param_o for port k is bits k*256 up to k*256+255. Inside that slice, parameter word i occupies bits i*32 up to i*32+31. Slots beyond the count are zero, and the slices of the other ports are zero. When no start is active, param_o is all zero.
- R5: When the trigger is already satisfied, start rises in the cycle right after the edge that accepts the last parameter word. A zero mask always counts as satisfied.
- R6: The trigger is satisfied only when each engine in the mask has had its done_i bit sampled high at a clock edge since the previous issue to the same opcode, or since reset. Start follows one cycle after the edge that samples the last missing done.
- R7: A done_i bit sampled at the edge that ends a start cycle counts toward the next trigger of that opcode.
- R8: in_ready is 0 from the cycle after the last parameter word is accepted up to and including the start cycle. It is 1 at all other times.
- R9: A parameter word accepted while no command word is pending sets err_o and is discarded without changing the next unit.
- R10: A command word with opcode above 5, or with a count of 0 or above 8, sets err_o and is discarded. The parameter words that follow it are then treated as stray words.
- R11: A command word that arrives while parameters are still being collected sets err_o and is discarded. Collection of the current unit continues unchanged.
- R12: err_o stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_word | input | 32 | Instruction word |
| in_valid | input | 1 | in_word is valid |
| in_ready | output | 1 | Block accepts in_word this cycle |
| done_i | input | 6 | Done flags from the six engines |
| start_o | output | 6 | One-cycle start per engine |
| param_o | output | 1536 | Six 256-bit parameter buses, one per engine |
| err_o | output | 1 | Sticky malformed-word flag |

## Verification
A miscounted parameter index shows up at the unit's start cycle. Either the start comes early or late relative to the last accepted word, or a parameter slot carries the wrong word or a stale nonzero value. Wrong done tracking shows within one cycle of the deciding done pulse: start fires before a masked engine has reported, or fails to fire once all of them have. A second unit sent to the same opcode exposes tracking that fails to clear at issue. A broken decode or state machine shows at the very next word: err_o rises on a legal word or stays low on a stray one, or in_ready stays high while a unit is held.

// File: rtl/cid_pkg.sv
// Shared constants and types for the conditional dispatch unit.
// Assumes 32-bit instruction words with a fixed field layout.
package cid_pkg;
    localparam int ENG_N     = 6;
    localparam int OP_W      = 3;
    localparam int CNT_W     = 4;
    localparam int CLASS_BIT = 31;
    localparam int OP_LSB    = 28;
    localparam int MASK_LSB  = 22;
    localparam int CNT_LSB   = 18;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GATHER = 2'd1,
        ST_WAIT   = 2'd2
    } disp_state_t;
endpackage

// File: rtl/cid_decode.sv
// Field decoder for one instruction word.
// Purely combinational; reports whether a command word is legal.
module cid_decode
    import cid_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int MAX_PARAMS = 8
) (
    input  logic [WORD_W-1:0] word,
    output logic              is_cmd,
    output logic [OP_W-1:0]   op,
    output logic [ENG_N-1:0]  mask,
    output logic [CNT_W-1:0]  cnt,
    output logic              cmd_ok
);
    // split fields and judge legality
    always_comb begin
        is_cmd = word[CLASS_BIT];
        op     = word[OP_LSB +: OP_W];
        mask   = word[MASK_LSB +: ENG_N];
        cnt    = word[CNT_LSB +: CNT_W];
        cmd_ok = (int'(op) < ENG_N) && (cnt != '0) && (int'(cnt) <= MAX_PARAMS);
    end
endmodule

// File: rtl/cid_gather.sv
// Unit collector: takes a command word, then its parameter words, then
// holds the unit until the trigger is met. Drops malformed words and
// raises a sticky error. Assumes sat is valid whenever the state is WAIT.
module cid_gather
    import cid_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int MAX_PARAMS = 8,
    localparam int PAR_W     = WORD_W * MAX_PARAMS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    input  logic              is_cmd,
    input  logic [OP_W-1:0]   dec_op,
    input  logic [ENG_N-1:0]  dec_mask,
    input  logic [CNT_W-1:0]  dec_cnt,
    input  logic              cmd_ok,
    input  logic              sat,
    output logic              in_ready,
    output logic              issue,
    output logic [OP_W-1:0]   op_q,
    output logic [ENG_N-1:0]  mask_q,
    output logic [PAR_W-1:0]  par_flat,
    output logic              err_o
);
    disp_state_t      st_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] idx_q;
    logic             err_q;
    logic             fire;
    logic             take_cmd;
    logic             take_par;

    // handshake and issue qualifiers
    always_comb begin
        in_ready = (st_q != ST_WAIT);
        fire     = in_valid && in_ready;
        take_cmd = fire && (st_q == ST_IDLE) && is_cmd && cmd_ok;
        take_par = fire && (st_q == ST_GATHER) && !is_cmd;
        issue    = (st_q == ST_WAIT) && sat;
    end

    // sequencing state, unit header and error flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            op_q   <= '0;
            mask_q <= '0;
            cnt_q  <= '0;
            idx_q  <= '0;
            err_q  <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (take_cmd) begin
                        op_q   <= dec_op;
                        mask_q <= dec_mask;
                        cnt_q  <= dec_cnt;
                        idx_q  <= '0;
                        st_q   <= ST_GATHER;
                    end else if (fire) begin
                        err_q <= 1'b1;
                    end
                end
                ST_GATHER: begin
                    if (fire && is_cmd) begin
                        err_q <= 1'b1;
                    end else if (take_par) begin
                        if (idx_q == cnt_q - CNT_W'(1)) begin
                            st_q <= ST_WAIT;
                        end else begin
                            idx_q <= idx_q + CNT_W'(1);
                        end
                    end
                end
                ST_WAIT: begin
                    if (sat) begin
                        st_q <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign err_o = err_q;

    // one storage slot per parameter word
    for (genvar k = 0; k < MAX_PARAMS; k++) begin : g_slot
        logic [WORD_W-1:0] slot_q;

        // clear on a new unit, load when this slot's word arrives
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (take_cmd) begin
                slot_q <= '0;
            end else if (take_par && (idx_q == CNT_W'(k))) begin
                slot_q <= in_word;
            end
        end

        assign par_flat[k*WORD_W +: WORD_W] = slot_q;
    end
endmodule

// File: rtl/cid_trigger.sv
// Done-tracking per target engine. For each opcode it records which
// engines have reported done since that opcode last issued, and judges
// whether the held unit's mask is covered. Assumes op_q < ENG_N in WAIT.
module cid_trigger
    import cid_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ENG_N-1:0] done_i,
    input  logic             issue,
    input  logic [OP_W-1:0]  op_q,
    input  logic [ENG_N-1:0] mask_q,
    output logic             sat
);
    logic [ENG_N-1:0] seen [ENG_N];
    logic [ENG_N-1:0] seen_sel;

    for (genvar t = 0; t < ENG_N; t++) begin : g_tgt
        logic [ENG_N-1:0] seen_q;

        // restart tracking on this target's issue, else accumulate
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                seen_q <= '0;
            end else if (issue && (op_q == OP_W'(t))) begin
                seen_q <= done_i;
            end else begin
                seen_q <= seen_q | done_i;
            end
        end

        assign seen[t] = seen_q;
    end

    // pick the tracking vector of the held unit's target
    always_comb begin
        seen_sel = '0;
        for (int t = 0; t < ENG_N; t++) begin
            if (op_q == OP_W'(t)) begin
                seen_sel = seen[t];
            end
        end
        sat = ((mask_q & ~seen_sel) == '0);
    end
endmodule

// File: rtl/cid_issue_port.sv
// Issue fan-out: one start bit and one parameter slice per engine.
// Slices stay zero except for the selected port in the start cycle.
module cid_issue_port
    import cid_pkg::*;
#(
    parameter int PAR_W = 256
) (
    input  logic               issue,
    input  logic [OP_W-1:0]    op_q,
    input  logic [PAR_W-1:0]   par_flat,
    output logic [ENG_N-1:0]   start_o,
    output logic [ENG_N*PAR_W-1:0] param_o
);
    for (genvar e = 0; e < ENG_N; e++) begin : g_port
        assign start_o[e]                = issue && (op_q == OP_W'(e));
        assign param_o[e*PAR_W +: PAR_W] = start_o[e] ? par_flat : '0;
    end
endmodule

// File: rtl/cond_issue_dispatch.sv
// Top of the conditional instruction dispatch unit: decodes incoming
// words, collects units, gates issue on engine done tracking and fans
// the unit out to six engine ports. Assumes one word per handshake.
module cond_issue_dispatch
    import cid_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int MAX_PARAMS = 8,
    localparam int PAR_W     = WORD_W * MAX_PARAMS,
    localparam int BUS_W     = ENG_N * PAR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] in_word,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ENG_N-1:0]  done_i,
    output logic [ENG_N-1:0]  start_o,
    output logic [BUS_W-1:0]  param_o,
    output logic              err_o
);
    logic             is_cmd;
    logic [OP_W-1:0]  dec_op;
    logic [ENG_N-1:0] dec_mask;
    logic [CNT_W-1:0] dec_cnt;
    logic             cmd_ok;
    logic             sat;
    logic             issue;
    logic [OP_W-1:0]  op_q;
    logic [ENG_N-1:0] mask_q;
    logic [PAR_W-1:0] par_flat;

    cid_decode #(.WORD_W(WORD_W), .MAX_PARAMS(MAX_PARAMS)) u_dec (
        .word(in_word), .is_cmd(is_cmd), .op(dec_op), .mask(dec_mask),
        .cnt(dec_cnt), .cmd_ok(cmd_ok)
    );

    cid_gather #(.WORD_W(WORD_W), .MAX_PARAMS(MAX_PARAMS)) u_gath (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .is_cmd(is_cmd), .dec_op(dec_op), .dec_mask(dec_mask),
        .dec_cnt(dec_cnt), .cmd_ok(cmd_ok), .sat(sat),
        .in_ready(in_ready), .issue(issue), .op_q(op_q), .mask_q(mask_q),
        .par_flat(par_flat), .err_o(err_o)
    );

    cid_trigger u_trig (
        .clk(clk), .rst_n(rst_n), .done_i(done_i), .issue(issue),
        .op_q(op_q), .mask_q(mask_q), .sat(sat)
    );

    cid_issue_port #(.PAR_W(PAR_W)) u_port (
        .issue(issue), .op_q(op_q), .par_flat(par_flat),
        .start_o(start_o), .param_o(param_o)
    );
endmodule

// File: rtl/cid_checker.sv
// Port-level properties of the dispatch unit, bound to the top module.
module cid_checker #(
    parameter int WORD_W = 32,
    parameter int ENG_N  = 6,
    parameter int BUS_W  = 1536
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] in_word,
    input logic              in_valid,
    input logic              in_ready,
    input logic [ENG_N-1:0]  start_o,
    input logic [BUS_W-1:0]  param_o,
    input logic              err_o
);
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (in_ready && !err_o && start_o == '0));

    assert_single_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(start_o));

    assert_start_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o != '0) |=> (start_o == '0));

    assert_quiet_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o == '0) |-> (param_o == '0));

    assert_stall_on_issue_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o != '0) |-> !in_ready);

    assert_ready_after_issue_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o != '0) |=> in_ready);

    assert_err_from_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> $past(in_valid && in_ready));

    assert_err_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);
endmodule

bind cond_issue_dispatch cid_checker #(
    .WORD_W(WORD_W), .ENG_N(cid_pkg::ENG_N), .BUS_W(BUS_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_word(in_word), .in_valid(in_valid),
    .in_ready(in_ready), .start_o(start_o), .param_o(param_o), .err_o(err_o)
);

// File: tb/cond_issue_dispatch_test.sv
module cond_issue_dispatch_test;
    localparam int BW = 1536;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [31:0]   in_word = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [5:0]    done_i = '0;
    logic [5:0]    start_o;
    logic [BW-1:0] param_o;
    logic          err_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    logic [5:0]  seen [6];
    logic [31:0] pv [8];

    cond_issue_dispatch uut (
        .clk(clk), .rst_n(rst_n), .in_word(in_word), .in_valid(in_valid),
        .in_ready(in_ready), .done_i(done_i), .start_o(start_o),
        .param_o(param_o), .err_o(err_o)
    );

    always #4 clk = ~clk;

    task automatic check(string req, logic [BW-1:0] act, logic [BW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    function automatic logic [31:0] mkc(int op, int mask, int cnt);
        return {1'b1, 3'(op), 6'(mask), 4'(cnt), 18'h0};
    endfunction

    function automatic logic [BW-1:0] exp_bus(int op, int n);
        logic [BW-1:0] v = '0;
        for (int k = 0; k < n; k++) v[op*256 + k*32 +: 32] = pv[k];
        return v;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; in_valid = 1'b0; done_i = '0;
        tick(); tick();
        rst_n = 1'b1;
        for (int t = 0; t < 6; t++) seen[t] = '0;
        tick();
    endtask

    task automatic send(logic [31:0] w);
        in_word = w; in_valid = 1'b1;
        while (!in_ready) tick();
        tick();
        in_valid = 1'b0;
    endtask

    task automatic pulse_done(logic [5:0] d);
        done_i = d;
        for (int t = 0; t < 6; t++) seen[t] = seen[t] | d;
        tick();
        done_i = '0;
    endtask

    // expects to be called at the negedge of the first WAIT cycle
    task automatic expect_issue(int op, int mask, int n, bit dn_at_issue);
        logic [5:0] need = 6'(mask) & ~seen[op];
        logic [5:0] d;
        if (need != 0) begin
            check("R6 held", BW'(start_o), '0);
            check("R8 stall", BW'(in_ready), BW'(0));
            tick();
            check("R6 still held", BW'(start_o), '0);
            pulse_done(need);
        end
        check("R3/R5 start", BW'(start_o), BW'(6'b1 << op));
        check("R4 params", param_o, exp_bus(op, n));
        check("R8 low at start", BW'(in_ready), BW'(0));
        d = dn_at_issue ? 6'($urandom) : 6'h0;
        done_i = d;
        for (int t = 0; t < 6; t++) seen[t] = (t == op) ? d : (seen[t] | d);
        tick();
        done_i = '0;
        check("R3 single pulse", BW'(start_o), '0);
        check("R8 ready again", BW'(in_ready), BW'(1));
    endtask

    task automatic run_unit(int op, int mask, int n, bit dn_at_issue);
        for (int k = 0; k < 8; k++) pv[k] = $urandom & 32'h7fff_ffff;
        send(mkc(op, mask, n));
        for (int k = 0; k < n; k++) send(pv[k]);
        expect_issue(op, mask, n, dn_at_issue);
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        tick();
        do_reset();
        // R1 reset state
        check("R1 ready", BW'(in_ready), BW'(1));
        check("R1 err", BW'(err_o), BW'(0));
        check("R1 start", BW'(start_o), '0);
        check("R1 bus", param_o, '0);

        // R2 R5 zero mask, each opcode, full and single counts
        for (int op = 0; op < 6; op++) run_unit(op, 0, (op % 2) ? 8 : 1, 0);
        check("R2 no err on legal words", BW'(err_o), BW'(0));

        // R6 partial coverage, then same target needs fresh done
        pulse_done(6'b000001);
        run_unit(3, 6'b010001, 2, 0);
        run_unit(3, 6'b000001, 3, 0);
        // R7 done during start cycle counts for next trigger
        pulse_done(6'b000100);
        run_unit(4, 6'b000100, 1, 0);
        done_i = '0;
        for (int k = 0; k < 8; k++) pv[k] = $urandom & 32'h7fff_ffff;
        send(mkc(2, 6'b000010, 1));
        send(pv[0]);
        // give the start-cycle done explicitly
        check("R6 waiting on engine1", BW'(start_o), '0);
        pulse_done(6'b000010);
        check("R6 start", BW'(start_o), BW'(6'b000100));
        done_i = 6'b100000;
        tick();
        done_i = '0;
        seen[2] = 6'b100000;
        run_unit(2, 6'b100000, 1, 0);
        check("R7 no err", BW'(err_o), BW'(0));

        // R9 stray parameter word
        do_reset();
        send(32'h0123_4567);
        check("R9 err", BW'(err_o), BW'(1));
        check("R9 start untouched", BW'(start_o), '0);
        run_unit(1, 0, 2, 0);
        check("R12 err sticky", BW'(err_o), BW'(1));

        // R10 illegal opcode, zero and oversize count
        do_reset();
        send(mkc(6, 0, 2));
        check("R10 op6 err", BW'(err_o), BW'(1));
        send(32'h0000_1111);
        check("R10 no start", BW'(start_o), '0);
        do_reset();
        send(mkc(1, 0, 0));
        check("R10 cnt0 err", BW'(err_o), BW'(1));
        do_reset();
        send(mkc(1, 0, 9));
        check("R10 cnt9 err", BW'(err_o), BW'(1));
        run_unit(5, 0, 4, 0);

        // R11 command word during collection
        do_reset();
        for (int k = 0; k < 8; k++) pv[k] = $urandom & 32'h7fff_ffff;
        send(mkc(2, 0, 2));
        send(pv[0]);
        send(mkc(0, 0, 1));
        check("R11 err", BW'(err_o), BW'(1));
        check("R11 no start", BW'(start_o), '0);
        send(pv[1]);
        expect_issue(2, 0, 2, 0);
        check("R12 still set", BW'(err_o), BW'(1));

        // random units with masks and done traffic
        do_reset();
        for (int i = 0; i < 80; i++) begin
            int op = $urandom_range(5, 0);
            int n  = $urandom_range(8, 1);
            int m  = ($urandom_range(2, 0) == 0) ? int'($urandom_range(63, 0)) : 0;
            if ($urandom_range(3, 0) == 0) pulse_done(6'($urandom));
            run_unit(op, m, n, $urandom_range(1, 0) == 1);
        end
        check("R2 random no err", BW'(err_o), BW'(0));

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule